// File: doc/BRIEF.md
# Three-Stage Fetch/Decode/Execute Pipeline Controller

This block is the front end and sequencing control of a three-stage pipeline for a 32-bit processor whose instructions are all 4 bytes long. It drives the instruction-memory address and captures the word that the memory returns in the same cycle. It carries each instruction through a decode register and an execute register, and it tests the 4-bit condition field in bits [31:28] against the stored N, Z, C and V flags. Branches are resolved in the execute stage. A non-branch instruction whose condition holds is handed to an external datapath through an execute-request interface, and the datapath returns new flags for it.

Three branch kinds are resolved here: a relative branch, a relative branch that also writes a return address, and a register branch that can switch the instruction-state mode bit. Register storage and arithmetic belong to the datapath. For a register branch the datapath supplies the value of the register named in bits [3:0] of the instruction that is in execute. A stall input from the datapath freezes the whole pipeline. An exception-entry input forces the mode bit back to the 32-bit state.

Top module: `pipe3_ctrl`

## Requirements
- R1: A synchronous active-high reset sets the fetch address to 0 and empties decode and execute. No execute request appears in the first two cycles after reset, and the instruction fetched from address 0 reaches execute in the third cycle.
- R2: In each cycle with no stall and no taken branch, the fetch address advances by 4. Instructions then move fetch to decode to execute in order, one per stage, and `exec_instr` shows the word that was fetched from the executing address.
- R3: `exec_pc` equals the address of the executing instruction plus 8.
- R4: The condition field in bits [31:28] is evaluated against the flags {N,Z,C,V} as follows: 0 Z set, 1 Z clear, 2 C set, 3 C clear, 4 N set, 5 N clear, 6 V set, 7 V clear, 8 C set and Z clear, 9 C clear or Z set, A N equals V, B N differs from V, C Z clear and N equals V, D Z set or N differs from V, E always, F never. An instruction whose condition fails produces no execute request, no flag change and no branch, and it occupies its slot as a bubble.
- R5: A relative branch is a word with bits [27:25] = 101. When taken, the next fetch address is its own address + 8 + (sign-extended bits [23:0] × 4).
- R6: A taken branch pulses `branch_taken` and discards the two younger instructions. Execute is empty for the next two cycles.
- R7: A relative branch with bit 24 set raises `link_we` in the cycle it is taken, with `link_addr` = its own address + 4.
- R8: A register branch is a word with bits [27:4] = 0x12FFF1. When taken, the fetch resumes at `rm_value` with bit 0 cleared, and `mode_compact` takes `rm_value` bit 0 from the next cycle on.
- R9: `exc_entry` clears `mode_compact` at the next cycle, even during a stall, and it wins over a register branch in the same cycle.
- R10: While `stall` is high, the fetch address, both younger stages and the execute stage hold their contents. No branch is taken, no flags are written and no instruction is lost.
- R11: When an execute request is made with `flags_we` high and no stall, the flags take `flags_in` {N,Z,C,V} for the instructions that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | AW | Instruction fetch address |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| stall | input | 1 | Datapath stall; freezes every stage |
| flags_we | input | 1 | Datapath writes flags for the current request |
| flags_in | input | 4 | New flags {N,Z,C,V} |
| rm_value | input | AW | Value of the register selected by `exec_instr[3:0]` |
| exc_entry | input | 1 | Exception entry; forces the 32-bit mode |
| exec_valid | output | 1 | Execute request to the datapath |
| exec_instr | output | 32 | Instruction in execute |
| exec_pc | output | AW | Program counter as seen by that instruction (address + 8) |
| link_we | output | 1 | Return-address write strobe |
| link_addr | output | AW | Return address for the link register |
| branch_taken | output | 1 | A branch in execute is taken this cycle |
| mode_compact | output | 1 | 1 = compact 16-bit instruction state |

## Verification
A word fetched in cycle k, if nothing stalls, is presented on the execute outputs in cycle k+2, together with `exec_valid`, `branch_taken` and `link_we`. The new fetch address and the new mode bit appear in the cycle after the branch is taken, and a flag write affects condition results from the next cycle on. The bench keeps a queue of addresses that have been fetched but not yet executed: an instruction executes only when two entries are waiting. It drives inputs on the falling edge, lets them settle, and compares every output against the queue model in that same half-cycle. The model then advances by one rising edge. The stall, exception and flag inputs are drawn from a seeded generator at three different stall rates.

// File: rtl/p3_pkg.sv
package p3_pkg;
  localparam int INSTR_W = 32;

  typedef enum logic [3:0] {
    CC_EQ = 4'h0, CC_NE = 4'h1, CC_CS = 4'h2, CC_CC = 4'h3,
    CC_MI = 4'h4, CC_PL = 4'h5, CC_VS = 4'h6, CC_VC = 4'h7,
    CC_HI = 4'h8, CC_LS = 4'h9, CC_GE = 4'hA, CC_LT = 4'hB,
    CC_GT = 4'hC, CC_LE = 4'hD, CC_AL = 4'hE, CC_NV = 4'hF
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/p3_cond_check.sv
module p3_cond_check
  import p3_pkg::*;
(
  input  logic [3:0] cond_i,
  input  flags_t     fl_i,
  output logic       pass_o
);
  always_comb begin
    case (cond_e'(cond_i))
      CC_EQ:   pass_o = fl_i.z;
      CC_NE:   pass_o = !fl_i.z;
      CC_CS:   pass_o = fl_i.c;
      CC_CC:   pass_o = !fl_i.c;
      CC_MI:   pass_o = fl_i.n;
      CC_PL:   pass_o = !fl_i.n;
      CC_VS:   pass_o = fl_i.v;
      CC_VC:   pass_o = !fl_i.v;
      CC_HI:   pass_o = fl_i.c && !fl_i.z;
      CC_LS:   pass_o = !fl_i.c || fl_i.z;
      CC_GE:   pass_o = (fl_i.n == fl_i.v);
      CC_LT:   pass_o = (fl_i.n != fl_i.v);
      CC_GT:   pass_o = !fl_i.z && (fl_i.n == fl_i.v);
      CC_LE:   pass_o = fl_i.z || (fl_i.n != fl_i.v);
      CC_AL:   pass_o = 1'b1;
      default: pass_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/p3_branch_unit.sv
module p3_branch_unit
  import p3_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [AW-1:0]      reg_i,
  output logic               is_br_o,
  output logic               is_link_o,
  output logic               is_bx_o,
  output logic [AW-1:0]      target_o,
  output logic [AW-1:0]      link_o,
  output logic               mode_o
);
  localparam int OFF_W = 26;
  localparam int EXT_W = AW - OFF_W;

  logic          is_rel;
  logic [AW-1:0] offset;

  assign is_rel    = (instr_i[27:25] == 3'b101);
  assign is_bx_o   = (instr_i[27:4] == 24'h12FFF1);
  assign is_br_o   = is_rel || is_bx_o;
  assign is_link_o = is_rel && instr_i[24];

  generate
    if (EXT_W > 0) begin : g_ext
      assign offset = {{EXT_W{instr_i[23]}}, instr_i[23:0], 2'b00};
    end else begin : g_trunc
      assign offset = AW'({instr_i[23:0], 2'b00});
    end
  endgenerate

  assign target_o = is_bx_o ? {reg_i[AW-1:1], 1'b0}
                            : addr_i + AW'(8) + offset;
  assign link_o   = addr_i + AW'(4);
  assign mode_o   = reg_i[0];
endmodule

// File: rtl/pipe3_ctrl.sv
module pipe3_ctrl
  import p3_pkg::*;
#(
  parameter int            AW         = 32,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic               clk,
  input  logic               rst,
  output logic [AW-1:0]      imem_addr,
  input  logic [INSTR_W-1:0] imem_rdata,
  input  logic               stall,
  input  logic               flags_we,
  input  logic [3:0]         flags_in,
  input  logic [AW-1:0]      rm_value,
  input  logic               exc_entry,
  output logic               exec_valid,
  output logic [INSTR_W-1:0] exec_instr,
  output logic [AW-1:0]      exec_pc,
  output logic               link_we,
  output logic [AW-1:0]      link_addr,
  output logic               branch_taken,
  output logic               mode_compact
);
  localparam logic [AW-1:0] STEP = AW'(4);
  localparam logic [AW-1:0] LOOK = AW'(8);

  logic [AW-1:0]      pc_q;
  logic               dv_q, ev_q;
  logic [INSTR_W-1:0] d_instr_q, e_instr_q;
  logic [AW-1:0]      d_addr_q, e_addr_q;
  flags_t             fl_q;
  logic               mode_q;

  logic               pass, is_br, is_link, is_bx, new_mode, e_go, take;
  logic [AW-1:0]      target, ret_addr;

  p3_cond_check u_cond (
    .cond_i (e_instr_q[31:28]),
    .fl_i   (fl_q),
    .pass_o (pass)
  );

  p3_branch_unit #(.AW(AW)) u_br (
    .instr_i   (e_instr_q),
    .addr_i    (e_addr_q),
    .reg_i     (rm_value),
    .is_br_o   (is_br),
    .is_link_o (is_link),
    .is_bx_o   (is_bx),
    .target_o  (target),
    .link_o    (ret_addr),
    .mode_o    (new_mode)
  );

  assign e_go = ev_q && pass;
  assign take = e_go && is_br && !stall;

  // Stage valid bits and fetch address
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= RESET_ADDR;
      dv_q <= 1'b0;
      ev_q <= 1'b0;
    end else if (!stall) begin
      if (take) begin
        pc_q <= target;
        dv_q <= 1'b0;
        ev_q <= 1'b0;
      end else begin
        pc_q <= pc_q + STEP;
        dv_q <= 1'b1;
        ev_q <= dv_q;
      end
    end
  end

  // Stage payloads, no reset needed
  always_ff @(posedge clk) begin
    if (!stall && !take) begin
      d_instr_q <= imem_rdata;
      d_addr_q  <= pc_q;
      e_instr_q <= d_instr_q;
      e_addr_q  <= d_addr_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) fl_q <= '0;
    else if (e_go && !is_br && flags_we && !stall) fl_q <= flags_t'(flags_in);
  end

  always_ff @(posedge clk) begin
    if (rst)                 mode_q <= 1'b0;
    else if (exc_entry)      mode_q <= 1'b0;
    else if (take && is_bx)  mode_q <= new_mode;
  end

  assign imem_addr    = pc_q;
  assign exec_valid   = e_go && !is_br;
  assign exec_instr   = e_instr_q;
  assign exec_pc      = e_addr_q + LOOK;
  assign link_we      = take && is_link;
  assign link_addr    = ret_addr;
  assign branch_taken = take;
  assign mode_compact = mode_q;

  AST_SEQ_FETCH: assert property (@(posedge clk) disable iff (rst)
    (!stall && !branch_taken) |=> (imem_addr == $past(imem_addr) + STEP)); // R2
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(imem_addr)); // R10
  AST_FLUSH_BUBBLE: assert property (@(posedge clk) disable iff (rst)
    branch_taken |=> !exec_valid); // R6
  AST_EXEC_NOT_BRANCH: assert property (@(posedge clk) disable iff (rst)
    exec_valid |-> !branch_taken); // R4
  AST_LINK_WITH_TAKE: assert property (@(posedge clk) disable iff (rst)
    link_we |-> branch_taken); // R7
  AST_EXC_MODE: assert property (@(posedge clk) disable iff (rst)
    exc_entry |=> !mode_compact); // R9
endmodule

// File: tb/pipe3_ctrl_tb.sv
module pipe3_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int AW    = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] imem_addr;
  logic [31:0]   imem_rdata;
  logic          stall = 1'b0, flags_we = 1'b0, exc_entry = 1'b0;
  logic [3:0]    flags_in = 4'h0;
  logic [AW-1:0] rm_value;
  logic          exec_valid, link_we, branch_taken, mode_compact;
  logic [31:0]   exec_instr;
  logic [AW-1:0] exec_pc, link_addr;

  always #(CLK_P/2) clk = ~clk;

  logic [31:0] prog [64];
  logic [31:0] regs [16];

  assign imem_rdata = prog[imem_addr[7:2]];
  assign rm_value   = regs[exec_instr[3:0]];

  pipe3_ctrl #(.AW(AW)) u_dut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .stall(stall), .flags_we(flags_we), .flags_in(flags_in),
    .rm_value(rm_value), .exc_entry(exc_entry), .exec_valid(exec_valid),
    .exec_instr(exec_instr), .exec_pc(exec_pc), .link_we(link_we),
    .link_addr(link_addr), .branch_taken(branch_taken),
    .mode_compact(mode_compact)
  );

  int checks = 0;
  int errors = 0;
  bit [31:0] seed = 32'h1F2E3D4C;

  function automatic bit [31:0] rnd();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit cond_ok(logic [3:0] c, logic [3:0] f);
    bit n, z, cy, v;
    {n, z, cy, v} = f;
    case (c)
      4'h0: return z;
      4'h1: return !z;
      4'h2: return cy;
      4'h3: return !cy;
      4'h4: return n;
      4'h5: return !n;
      4'h6: return v;
      4'h7: return !v;
      4'h8: return cy && !z;
      4'h9: return !cy || z;
      4'hA: return n == v;
      4'hB: return n != v;
      4'hC: return !z && (n == v);
      4'hD: return z || (n != v);
      4'hE: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic make_program();
    for (int i = 0; i < 64; i++) begin
      bit [31:0] r = rnd();
      logic [3:0] c = (r[1:0] == 2'b00) ? 4'hE : r[31:28];
      int kind = int'(rnd() % 10);
      int off = int'(rnd() % 13) - 6;
      logic [31:0] w;
      if (off == -2) off = 1;
      if (kind < 2)       w = {c, 3'b101, 1'b0, 24'(off)};
      else if (kind == 2) w = {c, 3'b101, 1'b1, 24'(off)};
      else if (kind == 3) w = {c, 24'h12FFF1, r[7:4]};
      else begin
        w = {c, 3'b000, rnd()[24:0]};
        if (w[27:4] == 24'h12FFF1) w[4] = 1'b0;
      end
      prog[i] = w;
    end
    for (int i = 0; i < 16; i++) regs[i] = rnd() & 32'h0000_0FFF;
  endtask

  logic [31:0] q[$];
  logic [31:0] m_pc;
  logic [3:0]  m_fl;
  logic        m_mode;

  task automatic run(int n, int stall_pct, int exc_pct);
    bit prev_take = 0, prev_bx = 0, prev_stall = 0, prev_exc = 0;
    make_program();
    rst = 1'b1; stall = 1'b0; exc_entry = 1'b0; flags_we = 1'b0;
    repeat (3) @(negedge clk);
    q.delete(); m_pc = '0; m_fl = '0; m_mode = 1'b0;
    rst = 1'b0;
    for (int cyc = 0; cyc < n; cyc++) begin
      logic [31:0] ea, ei, tgt;
      bit pass, isb, isbx, exp_ev, exp_take, exp_link;
      stall     = (rnd() % 100) < stall_pct;
      exc_entry = (rnd() % 100) < exc_pct;
      flags_we  = rnd()[0];
      flags_in  = rnd()[3:0];
      #1;
      exp_ev = 0; exp_take = 0; exp_link = 0; isbx = 0; ea = '0; ei = '0; tgt = '0;
      if (q.size() == 2) begin
        ea   = q[0];
        ei   = prog[ea[7:2]];
        pass = cond_ok(ei[31:28], m_fl);
        isb  = (ei & 32'h0E00_0000) == 32'h0A00_0000;
        isbx = (ei & 32'h0FFF_FFF0) == 32'h012F_FF10;
        exp_ev   = pass && !(isb || isbx);
        exp_take = pass && (isb || isbx) && !stall;
        exp_link = exp_take && isb && ei[24];
        if (isbx) tgt = regs[ei[3:0]] & 32'hFFFF_FFFE;
        else tgt = ea + 32'd8 + ({{8{ei[23]}}, ei[23:0]} << 2);
      end
      // R1 reset behaviour, R2/R5/R8/R10 fetch address
      chk(imem_addr == m_pc,
          cyc == 0 ? "R1" : prev_bx ? "R8" : prev_take ? "R5" : prev_stall ? "R10" : "R2",
          "fetch address", imem_addr, m_pc);
      chk(exec_valid == exp_ev, cyc < 3 ? "R1" : "R4 R11", "exec_valid",
          32'(exec_valid), 32'(exp_ev));
      if (exp_ev) begin
        chk(exec_instr == ei, "R2", "exec_instr", exec_instr, ei);
        chk(exec_pc == ea + 32'd8, "R3", "exec_pc", exec_pc, ea + 32'd8);
      end
      chk(branch_taken == exp_take, "R6", "branch_taken", 32'(branch_taken), 32'(exp_take));
      chk(link_we == exp_link, "R7", "link_we", 32'(link_we), 32'(exp_link));
      if (exp_link) chk(link_addr == ea + 32'd4, "R7", "link_addr", link_addr, ea + 32'd4);
      chk(mode_compact == m_mode, prev_exc ? "R9" : "R8", "mode", 32'(mode_compact), 32'(m_mode));
      // advance the model by one rising edge
      if (!stall) begin
        if (exp_take) begin
          q.delete();
          m_pc = tgt;
        end else begin
          q.push_back(m_pc);
          if (q.size() > 2) void'(q.pop_front());
          m_pc = m_pc + 32'd4;
        end
      end
      if (exp_ev && flags_we && !stall) m_fl = flags_in;   // R11
      if (exc_entry) m_mode = 1'b0;                       // R9
      else if (exp_take && isbx) m_mode = regs[ei[3:0]][0];
      prev_take = exp_take; prev_bx = exp_take && isbx;
      prev_stall = stall; prev_exc = exc_entry;
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    run(2000, 0, 0);
    run(3000, 25, 5);
    run(3000, 50, 10);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule